// File: doc/BRIEF.md
# Bus Data Trigger Unit

This block watches the data bus of a processor and raises debug events when a programmed condition is seen. It has two comparators. Each one can test either the bus address or the bus data against a programmed value, and each can be limited to read cycles, to write cycles, or to both. The two comparators can also be joined so that together they detect an inclusive window of addresses or data values. Only bus cycles marked by the valid strobe are looked at.

Each trigger has its own routing to three actions:
- a halt request, which stays set until software clears it;
- a trace-start flag, which is latched in the same way;
- a single-cycle pulse on the external trigger pin.

A typical use is a stack guard. Place a write-only address match halfway into a 1024-word stack based at zero, and a write to address 512 raises the event. Configuration is written through a simple register port of select and data. Events appear one clock after the matching bus cycle is sampled.

Register layout on the configuration port:
- Select 0 and 2 hold the control words of comparator 0 and comparator 1.
- Select 1 and 3 hold their compare values.
- Select 4 holds routing and mode.
- Select 5 is a clear strobe. It stores nothing.

The reset input is asynchronous and active low. The unit synchronises its release over two clock edges.

Top module: `bus_trigger_unit`

## Requirements
- R1: A comparator whose enable bit (control bit 0) is zero never fires, whatever the bus does.
- R2: With control bit 1 = 0 the comparator matches when the bus address equals its value; with write-only direction (bit 3 set, bit 2 clear), a write to address 512 fires and a read of 512 or a write to 511 does not.
- R3: With control bit 1 = 1 the comparator matches on the bus data equal to its value and ignores the address.
- R4: Control bit 2 allows read cycles and bit 3 allows write cycles; with both set either direction fires, with both clear none does.
- R5: No action is raised for a cycle in which the bus valid strobe is low.
- R6: With routing bit 8 set (range mode), trigger 0 fires when comparator 0's operand is at least value 0 and comparator 1's operand is at most value 1, both inclusive, both comparators enabled and direction-qualified.
- R7: In range mode trigger 1 never fires, so only trigger 0's routing acts, even on an exact match with comparator 1's value.
- R8: The halt request rises one clock after a routed match and stays set until a write to select 5 with bit 0 set; a match in the same cycle as the clear wins.
- R9: The trace-start output rises one clock after a routed match and stays set until a write to select 5 with bit 1 set.
- R10: The external trigger output is high for exactly the one clock that follows each matching bus cycle.
- R11: Routing bits [2:0] (halt, trace, pulse) apply to trigger 0 and bits [6:4] to trigger 1, independently.
- R12: After reset all outputs are low and every configuration register is zero, so no bus cycle fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus cycle valid strobe |
| bus_write_i | input | 1 | 1 for a write cycle, 0 for a read |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_data_i | input | DATA_W | Bus data |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | CMP_W | Configuration write data (CMP_W is the larger of ADDR_W and DATA_W) |
| halt_req_o | output | 1 | Sticky halt request |
| trace_start_o | output | 1 | Latched trace-start flag |
| ext_trig_o | output | 1 | One-cycle external trigger pulse |

## Verification
The assertions check these properties on every cycle:
- the pulse output never follows a cycle without the valid strobe;
- halt and trace stay set until their clear is written;
- a rising halt is always backed by a halt routing bit.

Only the bench's scenarios can show which bus values actually fire. That covers the exact stack-guard address, the data select, the direction mask, the inclusive bounds of the window, and the suppression of trigger 1 in range mode. It also covers the priority of a match over a clear in the same cycle, which needs both stimuli timed together.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

  localparam int NUM_CMP = 2;

  // Register select codes on the configuration port
  localparam logic [2:0] SEL_ROUTE = 3'd4;
  localparam logic [2:0] SEL_CLEAR = 3'd5;
  localparam int RANGE_BIT = 8;
  localparam int ROUTE_STRIDE = 4;

  // Comparator control word, bit 0 is en
  typedef struct packed {
    logic allow_wr;
    logic allow_rd;
    logic use_data;
    logic en;
  } cmp_ctrl_t;

  // Per-trigger action routing, bit 0 is halt
  typedef struct packed {
    logic ext;
    logic trace;
    logic halt;
  } route_t;

endpackage

// File: rtl/bdt_cfg_regs.sv
module bdt_cfg_regs
  import bdt_pkg::*;
#(
  parameter int CMP_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_wr,
  input  logic [2:0]                        cfg_sel,
  input  logic [CMP_W-1:0]                  cfg_wdata,
  output cmp_ctrl_t [NUM_CMP-1:0]           ctrl,
  output logic [NUM_CMP-1:0][CMP_W-1:0]     value,
  output route_t [NUM_CMP-1:0]              route,
  output logic                              range_mode,
  output logic                              clr_halt,
  output logic                              clr_trace
);

  cmp_ctrl_t [NUM_CMP-1:0]          ctrl_q, ctrl_d;
  logic [NUM_CMP-1:0][CMP_W-1:0]    value_q, value_d;
  route_t [NUM_CMP-1:0]             route_q, route_d;
  logic                             range_q, range_d;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_regs
    localparam logic [2:0] CTRL_SEL = 3'(2 * i);
    localparam logic [2:0] VAL_SEL  = 3'(2 * i + 1);

    always_comb begin
      ctrl_d[i]  = ctrl_q[i];
      value_d[i] = value_q[i];
      route_d[i] = route_q[i];
      if (cfg_wr && cfg_sel == CTRL_SEL) ctrl_d[i] = cmp_ctrl_t'(cfg_wdata[3:0]);
      if (cfg_wr && cfg_sel == VAL_SEL) value_d[i] = cfg_wdata;
      if (cfg_wr && cfg_sel == SEL_ROUTE) route_d[i] = route_t'(cfg_wdata[ROUTE_STRIDE*i +: 3]);
    end
  end

  always_comb begin
    range_d = range_q;
    if (cfg_wr && cfg_sel == SEL_ROUTE) range_d = cfg_wdata[RANGE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      value_q <= '0;
      route_q <= '0;
      range_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      value_q <= value_d;
      route_q <= route_d;
      range_q <= range_d;
    end
  end

  assign ctrl       = ctrl_q;
  assign value      = value_q;
  assign route      = route_q;
  assign range_mode = range_q;
  assign clr_halt   = cfg_wr && cfg_sel == SEL_CLEAR && cfg_wdata[0];
  assign clr_trace  = cfg_wr && cfg_sel == SEL_CLEAR && cfg_wdata[1];

endmodule

// File: rtl/bdt_comparator.sv
module bdt_comparator
  import bdt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int CMP_W    = 32,
  parameter bit IS_UPPER = 1'b0
) (
  input  cmp_ctrl_t          ctrl,
  input  logic [CMP_W-1:0]   value,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_data,
  output logic               eq_hit,
  output logic               bound_hit
);

  logic [CMP_W-1:0] operand;
  logic             dir_ok;
  logic             qual;
  logic             side_ok;

  always_comb begin
    operand = ctrl.use_data ? CMP_W'(bus_data) : CMP_W'(bus_addr);
    dir_ok  = bus_write ? ctrl.allow_wr : ctrl.allow_rd;
    qual    = bus_valid && ctrl.en && dir_ok;
  end

  // One bound of the range window; the parameter picks which side
  if (IS_UPPER) begin : g_upper
    assign side_ok = (operand <= value);
  end else begin : g_lower
    assign side_ok = (operand >= value);
  end

  assign eq_hit    = qual && (operand == value);
  assign bound_hit = qual && side_ok;

  // R1: a disabled comparator raises neither output
  always_comb begin
    a_r1_disabled_silent: assert (ctrl.en || (!eq_hit && !bound_hit));
  end

endmodule

// File: rtl/bdt_action_ctrl.sv
module bdt_action_ctrl
  import bdt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CMP-1:0]    eq_hit,
  input  logic [NUM_CMP-1:0]    bound_hit,
  input  route_t [NUM_CMP-1:0]  route,
  input  logic                  range_mode,
  input  logic                  clr_halt,
  input  logic                  clr_trace,
  output logic                  halt_req,
  output logic                  trace_start,
  output logic                  ext_trig
);

  logic [NUM_CMP-1:0] fire;
  logic want_halt, want_trace, want_ext;
  logic halt_q, halt_d, trace_q, trace_d, ext_q, ext_d;

  always_comb begin
    fire[0] = range_mode ? (&bound_hit) : eq_hit[0];
    fire[1] = range_mode ? 1'b0 : eq_hit[1];
    want_halt  = 1'b0;
    want_trace = 1'b0;
    want_ext   = 1'b0;
    for (int t = 0; t < NUM_CMP; t++) begin
      want_halt  = want_halt  | (fire[t] & route[t].halt);
      want_trace = want_trace | (fire[t] & route[t].trace);
      want_ext   = want_ext   | (fire[t] & route[t].ext);
    end
  end

  always_comb begin
    halt_d  = want_halt  | (halt_q  & ~clr_halt);
    trace_d = want_trace | (trace_q & ~clr_trace);
    ext_d   = want_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      trace_q <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      halt_q  <= halt_d;
      trace_q <= trace_d;
      ext_q   <= ext_d;
    end
  end

  assign halt_req    = halt_q;
  assign trace_start = trace_q;
  assign ext_trig    = ext_q;

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !clr_halt) |=> halt_q);

  a_r9_trace_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_q && !clr_trace) |=> trace_q);

  a_r11_halt_routed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> $past(route[0].halt || route[1].halt));

endmodule

// File: rtl/bus_trigger_unit.sv
module bus_trigger_unit
  import bdt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CMP_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              cfg_wr_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [CMP_W-1:0]  cfg_wdata_i,
  output logic              halt_req_o,
  output logic              trace_start_o,
  output logic              ext_trig_o
);

  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmp_ctrl_t [NUM_CMP-1:0]       ctrl;
  logic [NUM_CMP-1:0][CMP_W-1:0] value;
  route_t [NUM_CMP-1:0]          route;
  logic                          range_mode, clr_halt, clr_trace;
  logic [NUM_CMP-1:0]            eq_hit, bound_hit;

  bdt_cfg_regs #(.CMP_W(CMP_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_wr     (cfg_wr_i),
    .cfg_sel    (cfg_sel_i),
    .cfg_wdata  (cfg_wdata_i),
    .ctrl       (ctrl),
    .value      (value),
    .route      (route),
    .range_mode (range_mode),
    .clr_halt   (clr_halt),
    .clr_trace  (clr_trace)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    bdt_comparator #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CMP_W    (CMP_W),
      .IS_UPPER (i == 1)
    ) u_cmp (
      .ctrl      (ctrl[i]),
      .value     (value[i]),
      .bus_valid (bus_valid_i),
      .bus_write (bus_write_i),
      .bus_addr  (bus_addr_i),
      .bus_data  (bus_data_i),
      .eq_hit    (eq_hit[i]),
      .bound_hit (bound_hit[i])
    );
  end

  bdt_action_ctrl u_act (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .eq_hit      (eq_hit),
    .bound_hit   (bound_hit),
    .route       (route),
    .range_mode  (range_mode),
    .clr_halt    (clr_halt),
    .clr_trace   (clr_trace),
    .halt_req    (halt_req_o),
    .trace_start (trace_start_o),
    .ext_trig    (ext_trig_o)
  );

  // R5: an idle bus cycle never produces a pulse on the next clock
  a_r5_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_valid_i |=> !ext_trig_o);

  // R10: the pulse follows a sampled valid bus cycle
  a_r10_pulse_from_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_trig_o |-> $past(bus_valid_i));

endmodule

// File: tb/bus_trigger_unit_tb_top.sv
module bus_trigger_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_data;
  logic        cfg_wr;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        halt_req, trace_start, ext_trig;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_trigger_unit dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid_i   (bus_valid),
    .bus_write_i   (bus_write),
    .bus_addr_i    (bus_addr),
    .bus_data_i    (bus_data),
    .cfg_wr_i      (cfg_wr),
    .cfg_sel_i     (cfg_sel),
    .cfg_wdata_i   (cfg_wdata),
    .halt_req_o    (halt_req),
    .trace_start_o (trace_start),
    .ext_trig_o    (ext_trig)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // One bus cycle; on return the outputs reflect that cycle
  task automatic bus(input logic vld, input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = vld; bus_write = wr; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 halt after reset", halt_req, 1'b0);
    chk("R12 trace after reset", trace_start, 1'b0);
    chk("R12 ext after reset", ext_trig, 1'b0);
    bus(1, 1, 32'd0, 32'd0);
    chk("R12 R1 zero config silent", ext_trig | halt_req | trace_start, 1'b0);
  endtask

  task automatic t_stack_guard();
    cfg(3'd2, 0); cfg(3'd0, 32'h9); cfg(3'd1, 32'd512); cfg(3'd4, 32'h1);
    bus(1, 0, 32'd512, 0);
    chk("R2 read of 512 ignored", halt_req, 1'b0);
    bus(1, 1, 32'd511, 0);
    chk("R2 write of 511 ignored", halt_req, 1'b0);
    bus(1, 1, 32'd512, 0);
    chk("R2 write of 512 halts", halt_req, 1'b1);
    bus(1, 1, 32'd100, 0);
    chk("R8 halt stays set", halt_req, 1'b1);
    cfg(3'd5, 32'h2);
    chk("R8 trace clear leaves halt", halt_req, 1'b1);
    cfg(3'd5, 32'h1);
    chk("R8 halt cleared", halt_req, 1'b0);
    cfg(3'd0, 32'h8);
    bus(1, 1, 32'd512, 0);
    chk("R1 disabled comparator silent", halt_req, 1'b0);
  endtask

  task automatic t_data_match();
    cfg(3'd0, 0); cfg(3'd2, 32'hF); cfg(3'd3, 32'hDEAD); cfg(3'd4, 32'h40);
    bus(1, 1, 32'd5, 32'hDEAD);
    chk("R3 data match pulses", ext_trig, 1'b1);
    @(negedge clk);
    chk("R10 pulse lasts one clock", ext_trig, 1'b0);
    bus(1, 0, 32'd5, 32'hDEAE);
    chk("R3 other data silent", ext_trig, 1'b0);
    bus(1, 1, 32'hDEAD, 32'd0);
    chk("R3 address ignored in data mode", ext_trig, 1'b0);
  endtask

  task automatic t_direction();
    cfg(3'd2, 0); cfg(3'd0, 32'hD); cfg(3'd1, 32'h40); cfg(3'd4, 32'h2);
    bus(1, 0, 32'h40, 0);
    chk("R4 read fires with both allowed", trace_start, 1'b1);
    bus(1, 0, 32'h0, 0);
    chk("R9 trace latched", trace_start, 1'b1);
    cfg(3'd5, 32'h2);
    chk("R9 trace cleared", trace_start, 1'b0);
    bus(1, 1, 32'h40, 0);
    chk("R4 write fires with both allowed", trace_start, 1'b1);
    cfg(3'd5, 32'h2);
    cfg(3'd0, 32'h1);
    bus(1, 0, 32'h40, 0);
    chk("R4 empty mask never fires", trace_start, 1'b0);
  endtask

  task automatic t_valid_gate();
    cfg(3'd0, 32'h9); cfg(3'd1, 32'h40); cfg(3'd4, 32'h5);
    bus(0, 1, 32'h40, 0);
    chk("R5 invalid cycle no pulse", ext_trig, 1'b0);
    chk("R5 invalid cycle no halt", halt_req, 1'b0);
  endtask

  task automatic t_range();
    cfg(3'd0, 32'hD); cfg(3'd1, 32'd100); cfg(3'd2, 32'hD); cfg(3'd3, 32'd200);
    cfg(3'd4, 32'h114);
    bus(1, 0, 32'd99, 0);
    chk("R6 below lower bound", ext_trig, 1'b0);
    bus(1, 1, 32'd100, 0);
    chk("R6 lower bound inclusive", ext_trig, 1'b1);
    bus(1, 0, 32'd200, 0);
    chk("R6 upper bound inclusive", ext_trig, 1'b1);
    chk("R7 trigger 1 silent on its exact value", halt_req, 1'b0);
    bus(1, 0, 32'd201, 0);
    chk("R6 above upper bound", ext_trig, 1'b0);
    bus(1, 1, 32'd150, 0);
    chk("R6 inside window", ext_trig, 1'b1);
    chk("R7 no halt in range mode", halt_req, 1'b0);
  endtask

  task automatic t_routing();
    cfg(3'd0, 32'h9); cfg(3'd1, 32'd10); cfg(3'd2, 32'h9); cfg(3'd3, 32'd20);
    cfg(3'd4, 32'h41);
    bus(1, 1, 32'd10, 0);
    chk("R11 trigger 0 halts", halt_req, 1'b1);
    chk("R11 trigger 0 no pulse", ext_trig, 1'b0);
    cfg(3'd5, 32'h1);
    bus(1, 1, 32'd20, 0);
    chk("R11 trigger 1 pulses", ext_trig, 1'b1);
    chk("R11 trigger 1 no halt", halt_req, 1'b0);
    chk("R11 no trace routed", trace_start, 1'b0);
    // Match and clear in the same cycle: the match wins
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'd10;
    cfg_wr = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'h1;
    @(negedge clk);
    bus_valid = 1'b0; cfg_wr = 1'b0;
    chk("R8 match beats clear", halt_req, 1'b1);
    cfg(3'd5, 32'h1);
    chk("R8 clear afterwards", halt_req, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_data = '0;
    cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_stack_guard();
    t_data_match();
    t_direction();
    t_valid_gate();
    t_range();
    t_routing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule